// File: doc/BRIEF.md
# Interrupt Request Gate with Stack-Pointer Pairing

This block keeps one pending flag per peripheral interrupt source and a mask bit per source. It merges the pending flags that are unmasked with the CPU's global enable into a single maskable request. The index of the winning source travels with that request. A second path carries a non-maskable request, taken on a rising edge of its input.

Both request paths are held off until software has written both stack pointers. This holds after reset, and again whenever one stack pointer is rewritten without its partner. The block sees only the write strobes of the two stack-pointer registers; the registers themselves live elsewhere. A non-maskable edge that arrives while the paths are held off is kept and delivered once the gate opens.

Top module: `irq_gate_ctrl`

## Requirements
- R1: After reset, `flags_o` is all zero, every mask bit is zero, `irq_o` is 0, `nmi_o` is 0 and the gate is closed.
- R2: A 1 on `src_evt[i]` in a cycle sets flag i, seen on `flags_o[i]` after the next clock edge, whatever the mask bit of source i holds.
- R3: A 1 on `flag_clr[i]` clears flag i at the next edge. If `src_evt[i]` is also 1 in that cycle, the flag stays set.
- R4: `mask_wr`=1 loads `mask_wdata` into the mask at the next edge (bit i = 1 enables source i). `irq_o` = gate open AND `gie` AND (any flag whose mask bit is 1).
- R5: `irq_idx_o` gives the lowest bit position set in (flags AND mask), or 0 when that vector is zero.
- R6: From reset, `irq_o` and `nmi_o` stay 0 until both `sp_a_wr` and `sp_b_wr` have been seen, in either order or in the same cycle. The gate opens at the edge that completes the pair.
- R7: While the gate is open, a write to only one stack pointer closes it at the next edge. Further writes to that same pointer keep it closed. A write to the other pointer reopens it.
- R8: A 0-to-1 change on `nmi_in`, sampled at clock edges, makes the non-maskable request pending. `nmi_o` = gate open AND pending. `nmi_ack`=1 clears the pending state, unless a new edge arrives in the same cycle.
- R9: A non-maskable edge taken while the gate is closed stays pending and appears on `nmi_o` right after the gate opens.
- R10: A flag left set raises `irq_o` again as soon as `gie` returns to 1, with no new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_evt | input | N_SRC | Per-source event strobes |
| flag_clr | input | N_SRC | Write-1-to-clear strobes for the flags |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | N_SRC | New mask value |
| gie | input | 1 | CPU global interrupt enable |
| nmi_in | input | 1 | Non-maskable request line, rising edge taken |
| nmi_ack | input | 1 | CPU accepts the non-maskable request |
| sp_a_wr | input | 1 | Write strobe of the first stack pointer |
| sp_b_wr | input | 1 | Write strobe of the second stack pointer |
| flags_o | output | N_SRC | Pending flags |
| irq_o | output | 1 | Maskable request to the CPU |
| irq_idx_o | output | IDX_W | Index of the winning source |
| nmi_o | output | 1 | Non-maskable request to the CPU |

## Verification
A wrong pairing state shows on the ports as a request that appears or stays away at the wrong time. It becomes visible in the first cycle after the stack-pointer write where a flag or a non-maskable edge is pending. Flag and mask faults show one edge after the event or the clear, as a wrong `flags_o` bit or a wrong `irq_o`/`irq_idx_o`. A lost non-maskable edge shows only when the gate next opens, so the stimulus opens and closes the gate many times while edges are outstanding.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

    typedef struct packed {
        logic seen_a;
        logic seen_b;
        logic open;
    } sp_pair_t;

    typedef struct packed {
        logic prev;
        logic pend;
    } nmi_state_t;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_evt,
    input  logic [N_SRC-1:0] flag_clr,
    input  logic             mask_wr,
    input  logic [N_SRC-1:0] mask_wdata,
    output logic [N_SRC-1:0] flags,
    output logic [N_SRC-1:0] pend
);
    typedef struct packed {
        logic [N_SRC-1:0] flags;
        logic [N_SRC-1:0] mask;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // event has priority over a clear in the same cycle
        st_d.flags = (st_q.flags & ~flag_clr) | src_evt;
        if (mask_wr) begin
            st_d.mask = mask_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flags;
    assign pend  = st_q.flags & st_q.mask;
endmodule

// File: rtl/irq_sp_pair.sv
module irq_sp_pair
    import irq_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sp_a_wr,
    input  logic sp_b_wr,
    output logic gate_open
);
    sp_pair_t st_d, st_q;
    logic have_a, have_b;

    always_comb begin
        st_d   = st_q;
        have_a = st_q.seen_a | sp_a_wr;
        have_b = st_q.seen_b | sp_b_wr;
        if (have_a && have_b) begin
            st_d.open   = 1'b1;
            st_d.seen_a = 1'b0;
            st_d.seen_b = 1'b0;
        end else if (sp_a_wr || sp_b_wr) begin
            st_d.open   = 1'b0;
            st_d.seen_a = have_a;
            st_d.seen_b = have_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_open = st_q.open;
endmodule

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge
    import irq_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_in,
    input  logic nmi_ack,
    output logic pending
);
    nmi_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = nmi_in;
        st_d.pend = (st_q.pend & ~nmi_ack) | (nmi_in & ~st_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending = st_q.pend;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N_SRC = 8,
    localparam int IDX_W = irq_gate_pkg::idx_width(N_SRC)
) (
    input  logic [N_SRC-1:0] pend,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl #(
    parameter int N_SRC = 8,
    localparam int IDX_W = irq_gate_pkg::idx_width(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_evt,
    input  logic [N_SRC-1:0] flag_clr,
    input  logic             mask_wr,
    input  logic [N_SRC-1:0] mask_wdata,
    input  logic             gie,
    input  logic             nmi_in,
    input  logic             nmi_ack,
    input  logic             sp_a_wr,
    input  logic             sp_b_wr,
    output logic [N_SRC-1:0] flags_o,
    output logic             irq_o,
    output logic [IDX_W-1:0] irq_idx_o,
    output logic             nmi_o
);
    logic [N_SRC-1:0] pend;
    logic             gate_open;
    logic             nmi_pend;

    irq_flag_bank #(.N_SRC(N_SRC)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_evt    (src_evt),
        .flag_clr   (flag_clr),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_wdata),
        .flags      (flags_o),
        .pend       (pend)
    );

    irq_sp_pair u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .sp_a_wr   (sp_a_wr),
        .sp_b_wr   (sp_b_wr),
        .gate_open (gate_open)
    );

    irq_nmi_edge u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_in  (nmi_in),
        .nmi_ack (nmi_ack),
        .pending (nmi_pend)
    );

    irq_prio_pick #(.N_SRC(N_SRC)) u_pick (
        .pend (pend),
        .idx  (irq_idx_o)
    );

    assign irq_o = gate_open & gie & (|pend);
    assign nmi_o = gate_open & nmi_pend;
endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk #(
    parameter int N_SRC = 8,
    localparam int IDX_W = irq_gate_pkg::idx_width(N_SRC)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src_evt,
    input logic [N_SRC-1:0] flag_clr,
    input logic             mask_wr,
    input logic [N_SRC-1:0] mask_wdata,
    input logic             gie,
    input logic             nmi_in,
    input logic             nmi_ack,
    input logic             sp_a_wr,
    input logic             sp_b_wr,
    input logic [N_SRC-1:0] flags_o,
    input logic             irq_o,
    input logic [IDX_W-1:0] irq_idx_o,
    input logic             nmi_o
);
    // R2: an event always leaves its flag set
    p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_evt != '0) |=> ((flags_o & $past(src_evt)) == $past(src_evt)));

    // R3: a clear without a concurrent event empties the flag
    p_flag_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_clr & ~src_evt) != '0) |=> ((flags_o & $past(flag_clr & ~src_evt)) == '0));

    // R4: the maskable request needs the enable and a pending flag
    p_irq_needs_gie_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (gie && (flags_o != '0)));

    // R5: the reported index points at a set flag
    p_idx_is_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flags_o[irq_idx_o]);

    // R8: an unacknowledged request holds while no stack pointer is written
    p_nmi_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_o && !nmi_ack && !sp_a_wr && !sp_b_wr) |=> nmi_o);
endmodule

bind irq_gate_ctrl irq_gate_chk #(.N_SRC(N_SRC)) u_chk (.*);

// File: tb/tb_irq_gate_ctrl.sv
module tb_irq_gate_ctrl;
    localparam int N = 8;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] src_evt = '0, flag_clr = '0, mask_wdata = '0;
    logic mask_wr = 0, gie = 0, nmi_in = 0, nmi_ack = 0, sp_a_wr = 0, sp_b_wr = 0;
    logic [N-1:0] flags_o;
    logic irq_o, nmi_o;
    logic [IW-1:0] irq_idx_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // bench model state
    logic [N-1:0] m_flags = '0, m_mask = '0;
    logic m_sa = 0, m_sb = 0, m_open = 0, m_nprev = 0, m_npend = 0;

    always #4 clk = ~clk;

    irq_gate_ctrl #(.N_SRC(N)) dut (.*);

    function automatic logic [IW-1:0] low_idx(input logic [N-1:0] v);
        logic [IW-1:0] r = '0;
        for (int i = N - 1; i >= 0; i--) if (v[i]) r = IW'(i);
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input string tag, input logic [N-1:0] ev, input logic [N-1:0] clr,
                        input logic mw, input logic [N-1:0] md, input logic g,
                        input logic ni, input logic na, input logic sa, input logic sb);
        logic a, b;
        @(negedge clk);
        src_evt = ev; flag_clr = clr; mask_wr = mw; mask_wdata = md; gie = g;
        nmi_in = ni; nmi_ack = na; sp_a_wr = sa; sp_b_wr = sb;
        @(posedge clk);
        m_flags = (m_flags & ~clr) | ev;
        if (mw) m_mask = md;
        m_npend = (m_npend & ~na) | (ni & ~m_nprev);
        m_nprev = ni;
        a = m_sa | sa; b = m_sb | sb;
        if (a && b) begin m_open = 1; m_sa = 0; m_sb = 0; end
        else if (sa || sb) begin m_open = 0; m_sa = a; m_sb = b; end
        #1;
        chk({"R2 R3 flags ", tag}, 32'(flags_o), 32'(m_flags));
        chk({"R4 R6 R7 R10 irq ", tag}, 32'(irq_o), 32'(m_open & g & (|(m_flags & m_mask))));
        chk({"R5 idx ", tag}, 32'(irq_idx_o), 32'(low_idx(m_flags & m_mask)));
        chk({"R8 R9 nmi ", tag}, 32'(nmi_o), 32'(m_open & m_npend));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 flags", 32'(flags_o), 0);
        chk("R1 irq", 32'(irq_o), 0);
        chk("R1 nmi", 32'(nmi_o), 0);
        @(negedge clk); rst_n = 1;
        // R2: masked events still set flags; gate closed (R6)
        step("R2", 8'h24, 0, 0, 0, 1, 0, 0, 0, 0);
        step("R6 mask", 0, 0, 1, 8'hFF, 1, 1, 0, 0, 0);
        step("R9 blocked", 0, 0, 0, 0, 1, 0, 0, 1, 0);
        step("R7 repeat a", 0, 0, 0, 0, 1, 0, 0, 1, 0);
        step("R6 open", 0, 0, 0, 0, 1, 0, 0, 0, 1);
        step("R8 ack", 0, 0, 0, 0, 1, 0, 1, 0, 0);
        step("R7 b only", 0, 0, 0, 0, 1, 0, 0, 0, 1);
        step("R7 a reopens", 0, 0, 0, 0, 1, 0, 0, 1, 0);
        step("R3 same cycle", 8'h01, 8'h01, 0, 0, 1, 0, 0, 0, 0);
        step("R3 clear", 0, 8'h01, 0, 0, 1, 0, 0, 0, 0);
        step("R10 gie off", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R10 gie on", 0, 0, 0, 0, 1, 0, 0, 0, 0);
        step("R6 both same", 0, 0, 0, 0, 1, 0, 0, 1, 1);
        step("R5 low", 8'h81, 8'h24, 1, 8'hFE, 1, 0, 0, 0, 0);
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] r = $urandom;
            step("rand", N'($urandom) & N'($urandom), N'($urandom) & N'($urandom),
                 r[0] & r[1], N'($urandom), r[2] | r[3], r[4], r[5] & r[6],
                 (r[11:8] == 0), (r[15:12] == 0));
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule